// File: doc/BRIEF.md
# Alternating-Polarity Prefix Adder

A combinational unsigned adder. It takes two operands of `WIDTH` bits and returns their sum and the carry out of the top bit. There is no carry-in, so bit 0 of the sum is formed without any carry.

The carries come from a parallel prefix network. Each stage of that network works in the logic polarity opposite to the stage before it:

- **Pre-processing.** Every bit is turned into a complemented generate (NAND of the operand bits) and a complemented propagate (XNOR of the operand bits).
- **Odd stages.** The combine cells take active-low pairs and return active-high results.
- **Even stages.** The combine cells take active-high pairs and return active-low results.
- **Same-parity edges.** A polarity-restoring inverter is placed only where a node is fed from a stage of the same parity.

The polarity of every carry is fixed by the stage that produces it, and the package records it. The post-processing XOR picks its true or inverted form per bit to match.

For the default 32-bit width the network has:

- 31 carry-only (semi) cells, one closing each column above bit 0.
- 23 full combine cells.
- A depth of 9 stages.

The first two stages build 2-bit and 4-bit groups. After that, the carries advance one 4-bit block per stage along the diagonal. A single 3-bit group in the top block keeps its bit 2 within the depth limit. In general the depth is `WIDTH/4 + 1`. `WIDTH` must be a power of two of at least 8.

Top module: `polar_prefix_adder`

## Requirements
- R1: `{carry_o, sum_o}` equals `a_i + b_i` computed as a `WIDTH+1`-bit unsigned sum, for every pair of operands; with both operands zero, all outputs are zero.
- R2: There is no carry-in. `sum_o[0]` equals `a_i[0]` XOR `b_i[0]`, so 1 + 1 gives sum 2 and carry_o 0.
- R3: `carry_o` is the carry out of bit `WIDTH-1`. All-ones plus one gives sum 0 with carry_o 1, and 0x80000000 added to itself gives sum 0 with carry_o 1.
- R4: Alternating bit patterns add correctly: 0x55555555 + 0xAAAAAAAA = 0xFFFFFFFF with carry_o 0; 0xAAAAAAAA doubled = 0x55555554 with carry_o 1; 0x55555555 doubled = 0xAAAAAAAA with carry_o 0.
- R5: A carry entering at bit 0 reaches every column. For every k from 1 to `WIDTH-1`, (2^k − 1) + 1 yields exactly 2^k with carry_o 0, whichever polarity the tree holds column k−1's carry in.
- R6: A carry stops at the first bit that does not propagate. For every k from 1 to `WIDTH-1`, (all-ones with bit k cleared) + 1 yields all-ones above bit k, bit k set, zeros below it, and carry_o 0.
- R7: When every bit propagates and none generates (`b_i` = ~`a_i`), the sum is all ones and carry_o is 0.
- R8: The same structure built with `WIDTH` = 8 (depth 3) satisfies R1 for all 65536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Low `WIDTH` bits of the sum |
| carry_o | output | 1 | Carry out of bit `WIDTH-1` |

## Verification
The bench builds the adder twice.

- **`WIDTH` = 32.** This is the full depth-9 tree. Walking-carry and carry-stop patterns send a carry into every column, so each carry is observed in the polarity its stage produces. Alternating, boundary and random operands cover the rest.
- **`WIDTH` = 8.** This is the smallest legal shape. It has a three-stage tree, the 3-bit top group and a same-parity edge, and it is small enough to walk every operand pair exhaustively.

// File: rtl/polar_prefix_pkg.sv
package polar_prefix_pkg;

  // Stage index of the node that produces carry out of bit idx.
  // Stage 0 is pre-processing (active low).
  function automatic int unsigned car_stage(int unsigned idx, int unsigned width);
    int unsigned blk;
    int unsigned pos;
    if (idx == 0) return 0;
    if (idx == 1) return 1;
    if (idx < 4)  return 2;
    blk = idx / 4;
    pos = idx % 4;
    if (pos == 2 && blk != width / 4 - 1) return blk + 3;
    return blk + 2;
  endfunction

  function automatic bit stage_is_low(int unsigned stg);
    return (stg % 2) == 0;
  endfunction

  function automatic bit car_is_low(int unsigned idx, int unsigned width);
    return stage_is_low(car_stage(idx, width));
  endfunction

endpackage

// File: rtl/polar_prefix_cells.sv
// Polarity flip on a same-parity edge.
module pol_flip (
  input  logic d_i,
  output logic q_o
);
  assign q_o = ~d_i;
endmodule

// Odd stage combine: active-low in, active-high out.
module odd_dot_cell (
  input  logic hi_p_ni,
  input  logic hi_g_ni,
  input  logic lo_p_ni,
  input  logic lo_g_ni,
  output logic p_o,
  output logic g_o
);
  assign p_o = ~(hi_p_ni | lo_p_ni);
  assign g_o = ~(hi_g_ni & (hi_p_ni | lo_g_ni));
endmodule

// Even stage combine: active-high in, active-low out.
module even_dot_cell (
  input  logic hi_p_i,
  input  logic hi_g_i,
  input  logic lo_p_i,
  input  logic lo_g_i,
  output logic p_no,
  output logic g_no
);
  assign p_no = ~(hi_p_i & lo_p_i);
  assign g_no = ~(hi_g_i | (hi_p_i & lo_g_i));
endmodule

// Odd stage carry-only: active-low in, true carry out.
module odd_semi_cell (
  input  logic hi_p_ni,
  input  logic hi_g_ni,
  input  logic lo_c_ni,
  output logic c_o
);
  assign c_o = ~(hi_g_ni & (hi_p_ni | lo_c_ni));
endmodule

// Even stage carry-only: active-high in, complemented carry out.
module even_semi_cell (
  input  logic hi_p_i,
  input  logic hi_g_i,
  input  logic lo_c_i,
  output logic c_no
);
  assign c_no = ~(hi_g_i | (hi_p_i & lo_c_i));
endmodule

// File: rtl/polar_prefix_nodes.sv
// Full combine node placed at STAGE; inputs arrive in the polarity of their
// source stages, flips are inserted on same-parity edges.
module dot_node #(
  parameter int unsigned STAGE    = 1,
  parameter int unsigned HI_STAGE = 0,
  parameter int unsigned LO_STAGE = 0
) (
  input  logic hi_p_i,
  input  logic hi_g_i,
  input  logic lo_p_i,
  input  logic lo_g_i,
  output logic p_o,
  output logic g_o
);
  localparam bit FLIP_HI = (HI_STAGE % 2) == (STAGE % 2);
  localparam bit FLIP_LO = (LO_STAGE % 2) == (STAGE % 2);

  logic hp, hg, lp, lg;

  if (FLIP_HI) begin : g_flip_hi
    pol_flip u_fp (.d_i(hi_p_i), .q_o(hp));
    pol_flip u_fg (.d_i(hi_g_i), .q_o(hg));
  end else begin : g_pass_hi
    assign hp = hi_p_i;
    assign hg = hi_g_i;
  end

  if (FLIP_LO) begin : g_flip_lo
    pol_flip u_fp (.d_i(lo_p_i), .q_o(lp));
    pol_flip u_fg (.d_i(lo_g_i), .q_o(lg));
  end else begin : g_pass_lo
    assign lp = lo_p_i;
    assign lg = lo_g_i;
  end

  if (STAGE % 2 == 1) begin : g_odd
    odd_dot_cell u_cell (
      .hi_p_ni(hp), .hi_g_ni(hg), .lo_p_ni(lp), .lo_g_ni(lg),
      .p_o(p_o), .g_o(g_o)
    );
  end else begin : g_even
    even_dot_cell u_cell (
      .hi_p_i(hp), .hi_g_i(hg), .lo_p_i(lp), .lo_g_i(lg),
      .p_no(p_o), .g_no(g_o)
    );
  end
endmodule

// Carry-only node closing one column.
module semi_node #(
  parameter int unsigned STAGE    = 1,
  parameter int unsigned HI_STAGE = 0,
  parameter int unsigned LO_STAGE = 0
) (
  input  logic hi_p_i,
  input  logic hi_g_i,
  input  logic lo_c_i,
  output logic c_o
);
  localparam bit FLIP_HI = (HI_STAGE % 2) == (STAGE % 2);
  localparam bit FLIP_LO = (LO_STAGE % 2) == (STAGE % 2);

  logic hp, hg, lc;

  if (FLIP_HI) begin : g_flip_hi
    pol_flip u_fp (.d_i(hi_p_i), .q_o(hp));
    pol_flip u_fg (.d_i(hi_g_i), .q_o(hg));
  end else begin : g_pass_hi
    assign hp = hi_p_i;
    assign hg = hi_g_i;
  end

  if (FLIP_LO) begin : g_flip_lo
    pol_flip u_fc (.d_i(lo_c_i), .q_o(lc));
  end else begin : g_pass_lo
    assign lc = lo_c_i;
  end

  if (STAGE % 2 == 1) begin : g_odd
    odd_semi_cell u_cell (.hi_p_ni(hp), .hi_g_ni(hg), .lo_c_ni(lc), .c_o(c_o));
  end else begin : g_even
    even_semi_cell u_cell (.hi_p_i(hp), .hi_g_i(hg), .lo_c_i(lc), .c_no(c_o));
  end
endmodule

// File: rtl/polar_prefix_pre.sv
module polar_prefix_pre #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gn_o,
  output logic [WIDTH-1:0] pn_o
);
  assign gn_o = ~(a_i & b_i);
  assign pn_o = ~(a_i ^ b_i);

  always_comb begin
    // R1
    gp_excl_chk: assert (((~gn_o) & (~pn_o)) == '0)
      else $error("generate and propagate both active");
  end
endmodule

// File: rtl/polar_prefix_tree.sv
module polar_prefix_tree
  import polar_prefix_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] gn_i,
  input  logic [WIDTH-1:1] pn_i,
  output logic [WIDTH-1:0] car_o
);
  localparam int unsigned HALF = WIDTH / 2;
  localparam int unsigned QUAR = WIDTH / 4;

  // stage 1 pair groups, active high; stage 2 blocks, active low
  logic [HALF-1:1] pr_p, pr_g;
  logic [QUAR-1:1] qd_p_n, qd_g_n;
  logic            tri_p_n, tri_g_n;

  for (genvar k = 1; k < HALF; k++) begin : g_pair
    dot_node #(.STAGE(1), .HI_STAGE(0), .LO_STAGE(0)) u_dot (
      .hi_p_i(pn_i[2*k+1]), .hi_g_i(gn_i[2*k+1]),
      .lo_p_i(pn_i[2*k]),   .lo_g_i(gn_i[2*k]),
      .p_o(pr_p[k]), .g_o(pr_g[k])
    );
  end

  for (genvar m = 1; m < QUAR; m++) begin : g_quad
    dot_node #(.STAGE(2), .HI_STAGE(1), .LO_STAGE(1)) u_dot (
      .hi_p_i(pr_p[2*m+1]), .hi_g_i(pr_g[2*m+1]),
      .lo_p_i(pr_p[2*m]),   .lo_g_i(pr_g[2*m]),
      .p_o(qd_p_n[m]), .g_o(qd_g_n[m])
    );
  end

  // 3-bit group for bit WIDTH-2, keeps that column at full depth
  dot_node #(.STAGE(2), .HI_STAGE(0), .LO_STAGE(1)) u_tri (
    .hi_p_i(pn_i[WIDTH-2]), .hi_g_i(gn_i[WIDTH-2]),
    .lo_p_i(pr_p[HALF-2]),  .lo_g_i(pr_g[HALF-2]),
    .p_o(tri_p_n), .g_o(tri_g_n)
  );

  assign car_o[0] = gn_i[0];

  semi_node #(.STAGE(1), .HI_STAGE(0), .LO_STAGE(0)) u_c1 (
    .hi_p_i(pn_i[1]), .hi_g_i(gn_i[1]), .lo_c_i(car_o[0]), .c_o(car_o[1])
  );
  semi_node #(.STAGE(2), .HI_STAGE(0), .LO_STAGE(1)) u_c2 (
    .hi_p_i(pn_i[2]), .hi_g_i(gn_i[2]), .lo_c_i(car_o[1]), .c_o(car_o[2])
  );
  semi_node #(.STAGE(2), .HI_STAGE(1), .LO_STAGE(1)) u_c3 (
    .hi_p_i(pr_p[1]), .hi_g_i(pr_g[1]), .lo_c_i(car_o[1]), .c_o(car_o[3])
  );

  // diagonal: each block hangs off the carry out of the block below
  for (genvar m = 1; m < QUAR; m++) begin : g_blk
    localparam int unsigned B = 4 * m;
    localparam int unsigned S = m + 2;

    semi_node #(.STAGE(S), .HI_STAGE(0), .LO_STAGE(S-1)) u_c0 (
      .hi_p_i(pn_i[B]), .hi_g_i(gn_i[B]), .lo_c_i(car_o[B-1]), .c_o(car_o[B])
    );
    semi_node #(.STAGE(S), .HI_STAGE(1), .LO_STAGE(S-1)) u_c1 (
      .hi_p_i(pr_p[2*m]), .hi_g_i(pr_g[2*m]), .lo_c_i(car_o[B-1]), .c_o(car_o[B+1])
    );
    if (m == QUAR - 1) begin : g_top
      semi_node #(.STAGE(S), .HI_STAGE(2), .LO_STAGE(S-1)) u_c2 (
        .hi_p_i(tri_p_n), .hi_g_i(tri_g_n), .lo_c_i(car_o[B-1]), .c_o(car_o[B+2])
      );
    end else begin : g_mid
      semi_node #(.STAGE(S+1), .HI_STAGE(0), .LO_STAGE(S)) u_c2 (
        .hi_p_i(pn_i[B+2]), .hi_g_i(gn_i[B+2]), .lo_c_i(car_o[B+1]), .c_o(car_o[B+2])
      );
    end
    semi_node #(.STAGE(S), .HI_STAGE(2), .LO_STAGE(S-1)) u_c3 (
      .hi_p_i(qd_p_n[m]), .hi_g_i(qd_g_n[m]), .lo_c_i(car_o[B-1]), .c_o(car_o[B+3])
    );
  end

  always_comb begin
    for (int m = 1; m < int'(QUAR); m++) begin
      // R5
      quad_prop_chk: assert ((~qd_p_n[m]) ==
        (~pn_i[4*m] & ~pn_i[4*m+1] & ~pn_i[4*m+2] & ~pn_i[4*m+3]))
        else $error("block propagate mismatch at block %0d", m);
    end
  end
endmodule

// File: rtl/polar_prefix_post.sv
module polar_prefix_post
  import polar_prefix_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] pn_i,
  input  logic [WIDTH-1:0] car_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  assign sum_o[0] = ~pn_i[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_sum
    if (car_is_low(i - 1, WIDTH)) begin : g_cn
      assign sum_o[i] = pn_i[i] ^ car_i[i-1];
    end else begin : g_ct
      assign sum_o[i] = ~(pn_i[i] ^ car_i[i-1]);
    end
  end

  if (car_is_low(WIDTH - 1, WIDTH)) begin : g_co_n
    assign carry_o = ~car_i[WIDTH-1];
  end else begin : g_co_t
    assign carry_o = car_i[WIDTH-1];
  end
endmodule

// File: rtl/polar_prefix_adder.sv
module polar_prefix_adder
  import polar_prefix_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] gn, pn, car_raw, car_true;

  polar_prefix_pre #(.WIDTH(WIDTH)) u_pre (
    .a_i(a_i), .b_i(b_i), .gn_o(gn), .pn_o(pn)
  );

  polar_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .gn_i(gn), .pn_i(pn[WIDTH-1:1]), .car_o(car_raw)
  );

  polar_prefix_post #(.WIDTH(WIDTH)) u_post (
    .pn_i(pn), .car_i(car_raw), .sum_o(sum_o), .carry_o(carry_o)
  );

  // true-form carries, used only by the checks below
  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    logic [i+1:0] col_sum;
    assign car_true[i] = car_is_low(i, WIDTH) ? ~car_raw[i] : car_raw[i];
    always_comb begin
      col_sum = {1'b0, a_i[i:0]} + {1'b0, b_i[i:0]};
      // R5
      car_col_chk: assert (car_true[i] == col_sum[i+1])
        else $error("carry column %0d wrong", i);
    end
  end

  always_comb begin
    // R1
    sum_ref_chk: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("sum mismatch");
    // R2
    bit0_chk: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
      else $error("bit 0 sees a carry-in");
    // R3
    cout_chk: assert (carry_o == car_true[WIDTH-1])
      else $error("carry_o not top column carry");
  end
endmodule

// File: tb/polar_prefix_adder_tb.sv
`timescale 1ns/1ps
module polar_prefix_adder_tb_top;
  localparam int unsigned W  = 32;
  localparam int unsigned WS = 8;
  localparam int unsigned WDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          co;
  logic [WS-1:0] as, bs, ss;
  logic          cs;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  polar_prefix_adder #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .sum_o(s), .carry_o(co)
  );
  polar_prefix_adder #(.WIDTH(WS)) dut8_i (
    .a_i(as), .b_i(bs), .sum_o(ss), .carry_o(cs)
  );

  // {a, b, expected {carry, sum}}
  localparam logic [96:0] VEC_TBL [14] = '{
    {32'h0000_0000, 32'h0000_0000, 33'h0_0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0001, 33'h1_0000_0000}, // R3
    {32'h5555_5555, 32'hAAAA_AAAA, 33'h0_FFFF_FFFF}, // R4
    {32'hAAAA_AAAA, 32'hAAAA_AAAA, 33'h1_5555_5554}, // R4
    {32'h5555_5555, 32'h5555_5555, 33'h0_AAAA_AAAA}, // R4
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 33'h1_FFFF_FFFE},
    {32'h8000_0000, 32'h8000_0000, 33'h1_0000_0000}, // R3
    {32'h7FFF_FFFF, 32'h0000_0001, 33'h0_8000_0000},
    {32'h0000_FFFF, 32'h0000_0001, 33'h0_0001_0000},
    {32'h0FFF_FFFF, 32'hF000_0001, 33'h1_0000_0000},
    {32'h1234_5678, 32'h9ABC_DEF0, 33'h0_ACF1_3568},
    {32'hFFFF_0000, 32'h0001_0000, 33'h1_0000_0000},
    {32'hDEAD_BEEF, 32'h2152_4111, 33'h1_0000_0000},
    {32'hFFFF_FFF0, 32'h0000_000F, 33'h0_FFFF_FFFF}
  };

  task automatic chk_exp(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [W:0] exp);
    a = x;
    b = y;
    #1;
    checks++;
    if ({co, s} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, {co, s}, exp);
    end
  endtask

  task automatic chk_w(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
    chk_exp(req, x, y, {1'b0, x} + {1'b0, y});
  endtask

  task automatic chk_s(input string req, input logic [WS-1:0] x, input logic [WS-1:0] y);
    logic [WS:0] exp;
    exp = {1'b0, x} + {1'b0, y};
    as = x;
    bs = y;
    #1;
    checks++;
    if ({cs, ss} !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, x, y, {cs, ss}, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    a = '0; b = '0; as = '0; bs = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 idle state: zero operands
    chk_exp("R1 zero", '0, '0, '0);
    chk_s("R1 zero narrow", '0, '0);

    for (int i = 0; i < 14; i++)
      chk_exp("R1 table", VEC_TBL[i][96:65], VEC_TBL[i][64:33], VEC_TBL[i][32:0]);

    // R2 no carry-in
    chk_exp("R2 one plus one", 32'd1, 32'd1, 33'd2);
    chk_exp("R2 one plus zero", 32'd1, 32'd0, 33'd1);

    // R3 carry out of the top bit
    chk_exp("R3 ones plus one", 32'hFFFF_FFFF, 32'd1, 33'h1_0000_0000);
    chk_exp("R3 msb doubled", 32'h8000_0000, 32'h8000_0000, 33'h1_0000_0000);

    // R4 alternating patterns
    chk_exp("R4 0101+1010", 32'h5555_5555, 32'hAAAA_AAAA, 33'h0_FFFF_FFFF);
    chk_exp("R4 1010 doubled", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 33'h1_5555_5554);
    chk_exp("R4 0101 doubled", 32'h5555_5555, 32'h5555_5555, 33'h0_AAAA_AAAA);

    // R5 walking carry into every column
    for (int k = 1; k < int'(W); k++)
      chk_exp("R5 walk", (32'd1 << k) - 32'd1, 32'd1, {1'b0, 32'd1 << k});

    // R6 carry stops at first non-propagating bit
    for (int k = 1; k < int'(W); k++)
      chk_exp("R6 stop", ~(32'd1 << k), 32'd1, {1'b0, ~((32'd1 << k) - 32'd1)});

    // R7 pure propagate
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] x;
      x = $urandom;
      chk_exp("R7 propagate only", x, ~x, {1'b0, 32'hFFFF_FFFF});
    end

    // R1 exhaustive low bits on the wide build
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        chk_w("R1 low bits", W'(x), W'(y));

    // R8 exhaustive narrow build
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        chk_s("R8 exhaustive", WS'(x), WS'(y));

    // R1 random
    for (int i = 0; i < 100000; i++)
      chk_w("R1 random", $urandom, $urandom);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule